// File: doc/BRIEF.md
# Fractional-N Divider Controller

This block is the digital control of a fractional-N main divider that runs on the VCO clock. It counts VCO cycles and emits a one-cycle pulse at the end of every divide cycle. At each pulse it adds a small fractional increment to an accumulator whose modulus is either 5 or 8. When that sum reaches the modulus, the cycle that follows is one VCO clock longer. Over Q cycles the mean ratio is therefore N plus the increment divided by Q.

Each pulse also opens a compensation window of fixed length. The window carries an amplitude code, the product of the accumulator value and a DAC setting. An external current DAC uses the window and the code to cancel the phase ripple that the dithering causes. New settings are written at any time. They are held back and take effect together at the next divide-cycle boundary, so the running cycle never changes length halfway. A resync input restarts the counter and empties the accumulator, for use when the loop leaves power-down.

Top module: `fracn_div_ctrl`

## Requirements
- R1: After reset, `div_pulse`, `comp_win`, `frac_acc` and `comp_amp` are all 0, and the first pulse comes DEF_N clock cycles after the last clock edge that sees reset high.
- R2: `div_pulse` is high for one cycle per divide cycle. Pulses are N_eff cycles apart, or N_eff+1 cycles apart when the accumulator step at the earlier pulse overflowed.
- R3: At each pulse, `frac_acc` becomes (previous value + increment) mod Q. An overflow (sum >= Q) lengthens the next cycle by one, and `frac_acc` does not change between pulses.
- R4: `cfg_mod` = 0 selects Q = 8 and `cfg_mod` = 1 selects Q = 5. With Q = 5, an increment of 5, 6 or 7 counts as 4.
- R5: A write (`cfg_wr` high for one cycle) stores ratio, increment, modulus and DAC code as pending. All four take effect together at the next pulse, and the accumulator step at that pulse already uses them. The cycle in progress keeps its length.
- R6: When a boundary applies a modulus different from the active one, the accumulator step at that boundary starts from 0.
- R7: A ratio below MIN_N is treated as MIN_N.
- R8: `comp_win` rises with each pulse and stays high for exactly WIN_LEN cycles. A pulse that comes inside an open window restarts the count.
- R9: `comp_amp` equals `frac_acc` times the applied DAC code from the pulse onward. It holds that value while `comp_win` is high and reads 0 while `comp_win` is low.
- R10: A cycle with `resync` high clears `frac_acc`, closes the window and suppresses any pulse. The next pulse comes N_eff cycles (active ratio) after that edge, and pending settings are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| resync | input | 1 | Restart counter, clear accumulator and window |
| cfg_wr | input | 1 | Store the four settings as pending |
| cfg_ratio | input | N_W | Integer divide ratio N |
| cfg_frac | input | NF_W | Fractional increment |
| cfg_mod | input | 1 | Modulus select: 0 gives 8, 1 gives 5 |
| cfg_dac | input | DAC_W | Compensation DAC code |
| div_pulse | output | 1 | One-cycle pulse at the end of each divide cycle |
| frac_acc | output | ACC_W | Accumulator value |
| comp_win | output | 1 | Compensation window |
| comp_amp | output | ACC_W+DAC_W | Compensation amplitude code |

## Verification
The hardest case to reach is a modulus change applied while the accumulator holds a value that is legal for modulo 8 but not for modulo 5. The stimulus first runs modulo 8 with an increment of 3 until the accumulator sits at 6, then writes modulo 5. A second hard case is a resync that lands between a write and the boundary that would apply it. A directed step writes new settings and pulses resync a few cycles later. Random phases then mix ratios near and below the floor, where the windows overlap, with occasional resyncs at arbitrary points in the cycle.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int unsigned QMOD_WIDE   = 8;
  localparam int unsigned QMOD_NARROW = 5;
endpackage

// File: rtl/fracn_cfg_stage.sv
module fracn_cfg_stage #(
  parameter int N_W   = 16,
  parameter int NF_W  = 3,
  parameter int DAC_W = 8,
  parameter int MIN_N = 512,
  parameter int DEF_N = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [N_W-1:0]   wr_n,
  input  logic [NF_W-1:0]  wr_nf,
  input  logic             wr_mod,
  input  logic [DAC_W-1:0] wr_dac,
  input  logic             boundary,
  output logic [N_W-1:0]   nxt_n,
  output logic [NF_W-1:0]  nxt_nf,
  output logic             nxt_mod,
  output logic [DAC_W-1:0] nxt_dac,
  output logic             mod_chg,
  output logic [N_W-1:0]   act_n_eff,
  output logic             act_mod
);
  localparam logic [N_W-1:0] FLOOR = N_W'(MIN_N);

  logic [N_W-1:0]   act_n, pend_n;
  logic [NF_W-1:0]  act_nf, pend_nf;
  logic [DAC_W-1:0] act_dac, pend_dac;
  logic             act_mod_q, pend_mod, pend_vld;

  function automatic logic [N_W-1:0] floor_n(input logic [N_W-1:0] n);
    return (n < FLOOR) ? FLOOR : n;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      act_n     <= N_W'(DEF_N);
      act_nf    <= '0;
      act_mod_q <= 1'b0;
      act_dac   <= '0;
      pend_n    <= '0;
      pend_nf   <= '0;
      pend_mod  <= 1'b0;
      pend_dac  <= '0;
      pend_vld  <= 1'b0;
    end else begin
      if (boundary && pend_vld) begin
        act_n     <= pend_n;
        act_nf    <= pend_nf;
        act_mod_q <= pend_mod;
        act_dac   <= pend_dac;
      end
      if (cfg_wr) begin
        pend_n   <= wr_n;
        pend_nf  <= wr_nf;
        pend_mod <= wr_mod;
        pend_dac <= wr_dac;
        pend_vld <= 1'b1;
      end else if (boundary) begin
        pend_vld <= 1'b0;
      end
    end
  end

  always_comb begin
    nxt_n     = floor_n(pend_vld ? pend_n : act_n);
    nxt_nf    = pend_vld ? pend_nf  : act_nf;
    nxt_mod   = pend_vld ? pend_mod : act_mod_q;
    nxt_dac   = pend_vld ? pend_dac : act_dac;
    mod_chg   = pend_vld && (pend_mod != act_mod_q);
    act_n_eff = floor_n(act_n);
    act_mod   = act_mod_q;
  end
endmodule

// File: rtl/fracn_cycle_counter.sv
module fracn_cycle_counter #(
  parameter int CW      = 17,
  parameter int RST_LEN = 512
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          resync,
  input  logic [CW-1:0] reload_len,
  input  logic [CW-1:0] restart_len,
  output logic          terminal
);
  logic [CW-1:0] cnt_q;

  assign terminal = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= CW'(RST_LEN - 1);
    else if (resync)   cnt_q <= restart_len - CW'(1);
    else if (terminal) cnt_q <= reload_len - CW'(1);
    else               cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/fracn_accum.sv
module fracn_accum
  import fracn_pkg::*;
#(
  parameter int ACC_W = 3,
  parameter int NF_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             resync,
  input  logic             step,
  input  logic [NF_W-1:0]  nf,
  input  logic             mod_sel,
  input  logic             mod_chg,
  output logic [ACC_W-1:0] acc_q,
  output logic [ACC_W-1:0] acc_nxt,
  output logic             ovf_nxt
);
  localparam int SW = ((ACC_W > NF_W) ? ACC_W : NF_W) + 1;

  logic [SW-1:0] q_val, base, inc, sum;

  always_comb begin
    q_val   = mod_sel ? SW'(QMOD_NARROW) : SW'(QMOD_WIDE);
    base    = mod_chg ? '0 : SW'(acc_q);
    inc     = (SW'(nf) >= q_val) ? (q_val - SW'(1)) : SW'(nf);
    sum     = base + inc;
    ovf_nxt = (sum >= q_val);
    acc_nxt = ACC_W'(ovf_nxt ? (sum - q_val) : sum);
  end

  always_ff @(posedge clk) begin
    if (rst || resync) acc_q <= '0;
    else if (step)     acc_q <= acc_nxt;
  end
endmodule

// File: rtl/fracn_comp_window.sv
module fracn_comp_window #(
  parameter int WIN_LEN = 128,
  parameter int ACC_W   = 3,
  parameter int DAC_W   = 8,
  parameter int AMP_W   = ACC_W + DAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             resync,
  input  logic             start,
  input  logic [ACC_W-1:0] acc_in,
  input  logic [DAC_W-1:0] dac_in,
  output logic             win,
  output logic [AMP_W-1:0] amp
);
  localparam int WCW = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;

  logic [WCW-1:0]   wcnt;
  logic [AMP_W-1:0] prod;

  assign prod = AMP_W'(acc_in) * AMP_W'(dac_in);

  always_ff @(posedge clk) begin
    if (rst || resync) begin
      win  <= 1'b0;
      wcnt <= '0;
      amp  <= '0;
    end else if (start) begin
      win  <= 1'b1;
      wcnt <= WCW'(WIN_LEN - 1);
      amp  <= prod;
    end else if (win) begin
      if (wcnt == '0) begin
        win <= 1'b0;
        amp <= '0;
      end else begin
        wcnt <= wcnt - WCW'(1);
      end
    end
  end
endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl #(
  parameter int N_W     = 16,
  parameter int NF_W    = 3,
  parameter int DAC_W   = 8,
  parameter int ACC_W   = 3,
  parameter int MIN_N   = 512,
  parameter int DEF_N   = 512,
  parameter int WIN_LEN = 128
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   resync,
  input  logic                   cfg_wr,
  input  logic [N_W-1:0]         cfg_ratio,
  input  logic [NF_W-1:0]        cfg_frac,
  input  logic                   cfg_mod,
  input  logic [DAC_W-1:0]       cfg_dac,
  output logic                   div_pulse,
  output logic [ACC_W-1:0]       frac_acc,
  output logic                   comp_win,
  output logic [ACC_W+DAC_W-1:0] comp_amp
);
  localparam int CW      = N_W + 1;
  localparam int AMP_W   = ACC_W + DAC_W;
  localparam int RST_LEN = (DEF_N < MIN_N) ? MIN_N : DEF_N;

  logic             terminal, boundary, mod_chg, act_mod, nxt_mod, ovf_nxt;
  logic [N_W-1:0]   nxt_n, act_n_eff;
  logic [NF_W-1:0]  nxt_nf;
  logic [DAC_W-1:0] nxt_dac;
  logic [ACC_W-1:0] acc_nxt;
  logic [CW-1:0]    reload_len, restart_len;

  assign boundary    = terminal && !resync;
  assign reload_len  = CW'(nxt_n) + CW'(ovf_nxt);
  assign restart_len = CW'(act_n_eff);

  fracn_cfg_stage #(
    .N_W(N_W), .NF_W(NF_W), .DAC_W(DAC_W), .MIN_N(MIN_N), .DEF_N(RST_LEN)
  ) cfg_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr),
    .wr_n(cfg_ratio), .wr_nf(cfg_frac), .wr_mod(cfg_mod), .wr_dac(cfg_dac),
    .boundary(boundary),
    .nxt_n(nxt_n), .nxt_nf(nxt_nf), .nxt_mod(nxt_mod), .nxt_dac(nxt_dac),
    .mod_chg(mod_chg), .act_n_eff(act_n_eff), .act_mod(act_mod)
  );

  fracn_cycle_counter #(.CW(CW), .RST_LEN(RST_LEN)) cnt_i (
    .clk(clk), .rst(rst), .resync(resync),
    .reload_len(reload_len), .restart_len(restart_len), .terminal(terminal)
  );

  fracn_accum #(.ACC_W(ACC_W), .NF_W(NF_W)) acc_i (
    .clk(clk), .rst(rst), .resync(resync), .step(boundary),
    .nf(nxt_nf), .mod_sel(nxt_mod), .mod_chg(mod_chg),
    .acc_q(frac_acc), .acc_nxt(acc_nxt), .ovf_nxt(ovf_nxt)
  );

  fracn_comp_window #(
    .WIN_LEN(WIN_LEN), .ACC_W(ACC_W), .DAC_W(DAC_W), .AMP_W(AMP_W)
  ) win_i (
    .clk(clk), .rst(rst), .resync(resync), .start(boundary),
    .acc_in(acc_nxt), .dac_in(nxt_dac), .win(comp_win), .amp(comp_amp)
  );

  always_ff @(posedge clk) begin
    if (rst) div_pulse <= 1'b0;
    else     div_pulse <= boundary;
  end
endmodule

// File: rtl/fracn_div_ctrl_chk.sv
module fracn_div_ctrl_chk #(
  parameter int ACC_W = 3,
  parameter int AMP_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             resync,
  input logic             div_pulse,
  input logic [ACC_W-1:0] frac_acc,
  input logic             comp_win,
  input logic [AMP_W-1:0] comp_amp,
  input logic             act_mod
);
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  p_acc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!div_pulse && !$past(resync)) |-> $stable(frac_acc));

  p_acc_range_r4: assert property (@(posedge clk) disable iff (rst)
    act_mod |-> (frac_acc < ACC_W'(5)));

  p_win_start_r8: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> comp_win);

  p_amp_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !comp_win |-> (comp_amp == '0));

  p_amp_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (comp_win && !div_pulse) |-> $stable(comp_amp));

  p_resync_clear_r10: assert property (@(posedge clk) disable iff (rst)
    resync |=> ((frac_acc == '0) && !comp_win && !div_pulse));
endmodule

bind fracn_div_ctrl fracn_div_ctrl_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) chk_i (
  .clk(clk), .rst(rst), .resync(resync), .div_pulse(div_pulse),
  .frac_acc(frac_acc), .comp_win(comp_win), .comp_amp(comp_amp),
  .act_mod(act_mod)
);

// File: tb/fracn_div_ctrl_tb_top.sv
module fracn_div_ctrl_tb_top;
  localparam int N_W = 16, NF_W = 3, DAC_W = 8, ACC_W = 3;
  localparam int MIN_N = 64, DEF_N = 100, WIN_LEN = 128, AMP_W = 11;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0, rst = 1'b1, resync = 1'b0, cfg_wr = 1'b0, cfg_mod = 1'b0;
  logic [N_W-1:0] cfg_ratio = '0;
  logic [NF_W-1:0] cfg_frac = '0;
  logic [DAC_W-1:0] cfg_dac = '0;
  logic div_pulse, comp_win;
  logic [ACC_W-1:0] frac_acc;
  logic [AMP_W-1:0] comp_amp;

  always #2 clk = ~clk;

  fracn_div_ctrl #(.N_W(N_W), .NF_W(NF_W), .DAC_W(DAC_W), .ACC_W(ACC_W),
    .MIN_N(MIN_N), .DEF_N(DEF_N), .WIN_LEN(WIN_LEN)) dut_i (
    .clk(clk), .rst(rst), .resync(resync), .cfg_wr(cfg_wr),
    .cfg_ratio(cfg_ratio), .cfg_frac(cfg_frac), .cfg_mod(cfg_mod),
    .cfg_dac(cfg_dac), .div_pulse(div_pulse), .frac_acc(frac_acc),
    .comp_win(comp_win), .comp_amp(comp_amp));

  int cyc = 0, checks = 0, errors = 0;
  bit rs_hit = 0, rst_hit = 0, done = 0;
  string ctx = "R1";

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rs_hit <= rst || resync;
    rst_hit <= rst;
  end

  // bench model state
  int m_n = DEF_N, m_nf = 0, m_mod = 0, m_dac = 0, m_acc = 0, m_amp = 0;
  int p_n, p_nf, p_mod, p_dac;
  bit p_vld = 0, have_p = 0;
  int ref_cyc = 0, exp_len = DEF_N, last_p = 0;

  function automatic int nclamp(int n); return (n < MIN_N) ? MIN_N : n; endfunction
  function automatic int qof(int md); return md ? 5 : 8; endfunction
  function automatic int nfe(int nf, int md); return (nf >= qof(md)) ? qof(md) - 1 : nf; endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) if (!done) begin
    if (rst_hit) begin
      m_n = DEF_N; m_nf = 0; m_mod = 0; m_dac = 0; p_vld = 0;
    end
    if (rs_hit) begin
      m_acc = 0; m_amp = 0; have_p = 0; ref_cyc = cyc; exp_len = nclamp(m_n);
    end else begin
      bit exp_p;
      exp_p = (cyc == ref_cyc + exp_len);
      if (div_pulse || exp_p)
        chk(div_pulse == exp_p, {"R2 pulse timing ", ctx}, int'(div_pulse), int'(exp_p));
      if (div_pulse) begin
        bit mchg, ov;
        int s;
        mchg = 0;
        if (p_vld) begin
          mchg = (p_mod != m_mod);
          m_n = p_n; m_nf = p_nf; m_mod = p_mod; m_dac = p_dac; p_vld = 0;
        end
        s = (mchg ? 0 : m_acc) + nfe(m_nf, m_mod);
        ov = (s >= qof(m_mod));
        m_acc = ov ? s - qof(m_mod) : s;
        chk(int'(frac_acc) == m_acc, {"R3/R4/R6 accumulator ", ctx}, int'(frac_acc), m_acc);
        m_amp = m_acc * m_dac;
        exp_len = nclamp(m_n) + int'(ov);
        ref_cyc = cyc; last_p = cyc; have_p = 1;
      end
    end
    begin
      bit exp_w;
      exp_w = have_p && ((cyc - last_p) < WIN_LEN);
      chk(comp_win == exp_w, "R8 window", int'(comp_win), int'(exp_w));
      chk(int'(comp_amp) == (exp_w ? m_amp : 0), "R9 amplitude", int'(comp_amp), exp_w ? m_amp : 0);
    end
  end

  always @(posedge clk) if (!done && cyc > WD_LIMIT) begin
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WD_LIMIT);
    finish_run();
  end

  task automatic wait_pulses(int k);
    repeat (k) begin
      @(negedge clk);
      while (!div_pulse) @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic wr(int n, int nf, int md, int dac);
    cfg_ratio = N_W'(n); cfg_frac = NF_W'(nf); cfg_mod = md[0]; cfg_dac = DAC_W'(dac);
    cfg_wr = 1'b1;
    p_n = n; p_nf = nf; p_mod = md; p_dac = dac; p_vld = 1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_resync();
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5eed);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(div_pulse == 1'b0, "R1 pulse after reset", int'(div_pulse), 0);
    chk(comp_win == 1'b0, "R1 window after reset", int'(comp_win), 0);
    chk(frac_acc == '0, "R1 accumulator after reset", int'(frac_acc), 0);
    chk(comp_amp == '0, "R1 amplitude after reset", int'(comp_amp), 0);
    wait_pulses(2);

    ctx = "R3 mod8";
    wr(150, 3, 0, 80);
    wait_pulses(10);

    ctx = "R6 modulus switch";
    wr(170, 2, 1, 128);
    wait_pulses(6);

    ctx = "R4 increment clamp";
    wr(140, 7, 1, 200);
    wait_pulses(6);

    ctx = "R7 ratio floor";
    wr(MIN_N - 10, 1, 1, 255);
    wait_pulses(6);

    ctx = "R5 pending";
    wr(300, 5, 0, 17);
    repeat (20) @(negedge clk);
    wr(210, 6, 0, 33);
    wait_pulses(4);

    ctx = "R10 resync";
    repeat (37) @(negedge clk);
    do_resync();
    wait_pulses(2);
    wr(120, 3, 1, 90);
    repeat (5) @(negedge clk);
    do_resync();
    wait_pulses(3);

    ctx = "R2 random";
    for (int it = 0; it < 40; it++) begin
      wr(40 + int'($urandom_range(0, 220)), int'($urandom_range(0, 7)),
         int'($urandom_range(0, 1)), int'($urandom_range(0, 255)));
      if ($urandom_range(0, 4) == 0) begin
        repeat (int'($urandom_range(1, 60))) @(negedge clk);
        do_resync();
      end
      wait_pulses(int'($urandom_range(1, 3)));
    end
    repeat (WIN_LEN + 5) @(negedge clk);
    finish_run();
  end
endmodule